// File: doc/BRIEF.md
# MMU Configuration and Fault Register File

This block holds the software-visible state of a page-table-based memory management unit. Software reaches it through a coprocessor-style port: a 4-bit register number, a read strobe, a write strobe, 32-bit write data, and a 2-bit TLB opcode that goes with writes. Reads are combinational, so read data is valid in the same cycle as the read strobe. Writes take effect at the next clock edge.

The translation logic reads the enable and protection bits, the table base and the per-domain access fields from dedicated outputs. When an access aborts, the translation logic drives an abort capture port with a fault type, a domain number and the faulting virtual address. The block records all three. Register number 8 holds no state. A write to it produces a one-cycle invalidate-all pulse, or a one-cycle invalidate-entry pulse that carries the write data as the address.

Top module: `mmu_regfile`

## Requirements
- R1: Every register and every output resets to zero while `rstN` is low, so the MMU starts disabled.
- R2: Register 1 is the control register. Bit 0 is the MMU enable, bit 1 is the alignment-check enable, bit 2 is protection bit S and bit 3 is protection bit R. Other bits are not stored and read as zero. The four stored bits appear on `ctlMmuEn`, `ctlAlignEn`, `ctlProtS` and `ctlProtR`. They change only after a write to register 1.
- R3: Register 2 is the translation table base. Only write bits 31:14 are stored, and bits 13:0 always read as zero. The stored value appears on `tableBase`.
- R4: Register 3 is domain access control. All 32 bits are stored, and bits [2n+1:2n] form the field for domain n (n = 0 to 15). The stored value appears on `domainAccess`.
- R5: When `abortValid` is high at a clock edge, register 5 becomes {24'b0, abortDomain, abortType}, with the domain in bits 7:4 and the type in bits 3:0. Register 6 becomes `abortAddr`.
- R6: Software can write registers 5 and 6. Register 5 keeps write bits 7:0, and its bits 31:8 read as zero. Register 6 keeps all 32 bits.
- R7: If an abort capture and a software write to register 5 or 6 fall in the same cycle, the abort values are stored.
- R8: A write to register 8 with `tlbOp` = 1 raises `tlbInvAll` for exactly the following cycle. Register 8 stores nothing.
- R9: A write to register 8 with `tlbOp` = 2 raises `tlbInvEntry` for exactly the following cycle. During that cycle `tlbInvAddr` holds the write data. At all other times `tlbInvAddr` is zero.
- R10: A write to register 8 with `tlbOp` equal to 0 or 3 produces no pulse. A read of register 8, or of any number other than 1, 2, 3, 5 and 6, returns zero. `rdData` is zero whenever `rdEn` is low.
- R11: A write to an unimplemented register number changes no stored register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 4 | Register number for the access |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| tlbOp | input | 2 | TLB opcode used with a register 8 write |
| rdData | output | 32 | Read data (combinational) |
| abortValid | input | 1 | Abort capture strobe |
| abortType | input | 4 | Fault type code |
| abortDomain | input | 4 | Domain of the faulting access |
| abortAddr | input | 32 | Faulting virtual address |
| ctlMmuEn | output | 1 | MMU enable |
| ctlAlignEn | output | 1 | Alignment check enable |
| ctlProtS | output | 1 | Protection scheme bit S |
| ctlProtR | output | 1 | Protection scheme bit R |
| tableBase | output | 32 | Translation table base, low 14 bits zero |
| domainAccess | output | 32 | Sixteen 2-bit domain access fields |
| tlbInvAll | output | 1 | One-cycle invalidate-all request |
| tlbInvEntry | output | 1 | One-cycle invalidate-entry request |
| tlbInvAddr | output | 32 | Address for the invalidate-entry request |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, a 14-bit table alignment and a 4-bit register number. With these values all sixteen register numbers are reachable, so every unimplemented slot is exercised. The directed sequences run invalidate pulses back to back, and they collide aborts with software writes to registers 5 and 6 as well as with writes to other registers. A long random phase then mixes reads, writes, opcodes and aborts in every combination and compares every output against the behavioural model.

// File: rtl/mmu_regs_pkg.sv
package mmu_regs_pkg;
  localparam int REG_NUM_W = 4;
  localparam int CTL_W = 4;

  localparam logic [REG_NUM_W-1:0] SEL_CTL = 4'd1;
  localparam logic [REG_NUM_W-1:0] SEL_BASE = 4'd2;
  localparam logic [REG_NUM_W-1:0] SEL_DOM = 4'd3;
  localparam logic [REG_NUM_W-1:0] SEL_FSTAT = 4'd5;
  localparam logic [REG_NUM_W-1:0] SEL_FADDR = 4'd6;
  localparam logic [REG_NUM_W-1:0] SEL_TLB = 4'd8;

  localparam int CTL_BIT_M = 0;
  localparam int CTL_BIT_A = 1;
  localparam int CTL_BIT_S = 2;
  localparam int CTL_BIT_R = 3;

  typedef enum logic [1:0] {
    TLB_NOP       = 2'd0,
    TLB_INV_ALL   = 2'd1,
    TLB_INV_ENTRY = 2'd2,
    TLB_RSVD      = 2'd3
  } tlbOp_e;

  typedef struct packed {
    logic wrCtl;
    logic wrBase;
    logic wrDom;
    logic wrFstat;
    logic wrFaddr;
    logic capAbort;
    logic invAll;
    logic invEntry;
  } regStrobe_t;
endpackage

// File: rtl/mmu_reg_ctrl.sv
module mmu_reg_ctrl
  import mmu_regs_pkg::*;
(
  input  logic [REG_NUM_W-1:0] regSel,
  input  logic                 wrEn,
  input  logic [1:0]           tlbOp,
  input  logic                 abortValid,
  output regStrobe_t           strb
);
  always_comb begin
    strb = '0;
    strb.capAbort = abortValid;
    if (wrEn) begin
      unique case (regSel)
        SEL_CTL:   strb.wrCtl = 1'b1;
        SEL_BASE:  strb.wrBase = 1'b1;
        SEL_DOM:   strb.wrDom = 1'b1;
        // hardware capture takes priority over software on the fault pair
        SEL_FSTAT: strb.wrFstat = !abortValid;
        SEL_FADDR: strb.wrFaddr = !abortValid;
        SEL_TLB: begin
          strb.invAll   = (tlbOp == TLB_INV_ALL);
          strb.invEntry = (tlbOp == TLB_INV_ENTRY);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mmu_reg_dp.sv
module mmu_reg_dp
  import mmu_regs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BASE_LSB = 14,
  parameter int FTYPE_W = 4,
  parameter int FDOM_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           strb,
  input  logic [REG_NUM_W-1:0] regSel,
  input  logic                 rdEn,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [FTYPE_W-1:0]   abortType,
  input  logic [FDOM_W-1:0]    abortDomain,
  input  logic [DATA_W-1:0]    abortAddr,
  output logic [DATA_W-1:0]    rdData,
  output logic [CTL_W-1:0]     ctlBits,
  output logic [DATA_W-1:0]    tableBase,
  output logic [DATA_W-1:0]    domainAccess,
  output logic                 tlbInvAll,
  output logic                 tlbInvEntry,
  output logic [DATA_W-1:0]    tlbInvAddr
);
  localparam int FS_W = FTYPE_W + FDOM_W;

  logic [CTL_W-1:0]           ctlQ;
  logic [DATA_W-1:BASE_LSB]   baseQ;
  logic [DATA_W-1:0]          domQ;
  logic [FS_W-1:0]            fstatQ;
  logic [DATA_W-1:0]          faddrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ        <= '0;
      baseQ       <= '0;
      domQ        <= '0;
      fstatQ      <= '0;
      faddrQ      <= '0;
      tlbInvAll   <= 1'b0;
      tlbInvEntry <= 1'b0;
      tlbInvAddr  <= '0;
    end else begin
      if (strb.wrCtl)  ctlQ  <= wrData[CTL_W-1:0];
      if (strb.wrBase) baseQ <= wrData[DATA_W-1:BASE_LSB];
      if (strb.wrDom)  domQ  <= wrData;
      if (strb.capAbort) begin
        fstatQ <= {abortDomain, abortType};
        faddrQ <= abortAddr;
      end else begin
        if (strb.wrFstat) fstatQ <= wrData[FS_W-1:0];
        if (strb.wrFaddr) faddrQ <= wrData;
      end
      tlbInvAll   <= strb.invAll;
      tlbInvEntry <= strb.invEntry;
      tlbInvAddr  <= strb.invEntry ? wrData : '0;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      unique case (regSel)
        SEL_CTL:   rdData[CTL_W-1:0] = ctlQ;
        SEL_BASE:  rdData = {baseQ, {BASE_LSB{1'b0}}};
        SEL_DOM:   rdData = domQ;
        SEL_FSTAT: rdData[FS_W-1:0] = fstatQ;
        SEL_FADDR: rdData = faddrQ;
        default:   rdData = '0;
      endcase
    end
  end

  assign ctlBits      = ctlQ;
  assign tableBase    = {baseQ, {BASE_LSB{1'b0}}};
  assign domainAccess = domQ;
endmodule

// File: rtl/mmu_regfile.sv
module mmu_regfile
  import mmu_regs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BASE_LSB = 14,
  parameter int FTYPE_W = 4,
  parameter int FDOM_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [REG_NUM_W-1:0] regSel,
  input  logic                 rdEn,
  input  logic                 wrEn,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [1:0]           tlbOp,
  output logic [DATA_W-1:0]    rdData,
  input  logic                 abortValid,
  input  logic [FTYPE_W-1:0]   abortType,
  input  logic [FDOM_W-1:0]    abortDomain,
  input  logic [DATA_W-1:0]    abortAddr,
  output logic                 ctlMmuEn,
  output logic                 ctlAlignEn,
  output logic                 ctlProtS,
  output logic                 ctlProtR,
  output logic [DATA_W-1:0]    tableBase,
  output logic [DATA_W-1:0]    domainAccess,
  output logic                 tlbInvAll,
  output logic                 tlbInvEntry,
  output logic [DATA_W-1:0]    tlbInvAddr
);
  regStrobe_t        strb;
  logic [CTL_W-1:0]  ctlBits;

  mmu_reg_ctrl u_ctrl (
    .regSel     (regSel),
    .wrEn       (wrEn),
    .tlbOp      (tlbOp),
    .abortValid (abortValid),
    .strb       (strb)
  );

  mmu_reg_dp #(
    .DATA_W   (DATA_W),
    .BASE_LSB (BASE_LSB),
    .FTYPE_W  (FTYPE_W),
    .FDOM_W   (FDOM_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .regSel       (regSel),
    .rdEn         (rdEn),
    .wrData       (wrData),
    .abortType    (abortType),
    .abortDomain  (abortDomain),
    .abortAddr    (abortAddr),
    .rdData       (rdData),
    .ctlBits      (ctlBits),
    .tableBase    (tableBase),
    .domainAccess (domainAccess),
    .tlbInvAll    (tlbInvAll),
    .tlbInvEntry  (tlbInvEntry),
    .tlbInvAddr   (tlbInvAddr)
  );

  assign ctlMmuEn   = ctlBits[CTL_BIT_M];
  assign ctlAlignEn = ctlBits[CTL_BIT_A];
  assign ctlProtS   = ctlBits[CTL_BIT_S];
  assign ctlProtR   = ctlBits[CTL_BIT_R];
endmodule

// File: rtl/mmu_regfile_chk.sv
module mmu_regfile_chk (
  input logic        clk,
  input logic        rstN,
  input logic [3:0]  regSel,
  input logic        rdEn,
  input logic        wrEn,
  input logic [31:0] wrData,
  input logic [1:0]  tlbOp,
  input logic [31:0] rdData,
  input logic        abortValid,
  input logic [3:0]  abortType,
  input logic [3:0]  abortDomain,
  input logic [31:0] abortAddr,
  input logic        ctlMmuEn,
  input logic        tlbInvAll,
  input logic        tlbInvEntry,
  input logic [31:0] tlbInvAddr
);
  // R8: an invalidate-all pulse needs a register 8 write with opcode 1 in the cycle before
  a_r8_invall_cause: assert property (@(posedge clk) disable iff (!rstN)
    tlbInvAll |-> $past(wrEn && regSel == 4'd8 && tlbOp == 2'd1));

  // R9: an entry pulse carries the write data from the cycle before
  a_r9_entry_addr: assert property (@(posedge clk) disable iff (!rstN)
    tlbInvEntry |-> ($past(wrEn && regSel == 4'd8 && tlbOp == 2'd2) && tlbInvAddr == $past(wrData)));

  // R9: the address output is zero outside an entry pulse
  a_r9_addr_idle: assert property (@(posedge clk) disable iff (!rstN)
    !tlbInvEntry |-> tlbInvAddr == 32'd0);

  // R10: the two invalidate requests never overlap
  a_r10_pulse_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(tlbInvAll && tlbInvEntry));

  // R2: the enable bit moves only after a write to register 1
  a_r2_enable_stable: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrEn && regSel == 4'd1) |-> $stable(ctlMmuEn));

  // R3: low bits of the table base read as zero
  a_r3_base_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regSel == 4'd2) |-> rdData[13:0] == 14'd0);

  // R5: a captured abort shows up in the fault status register
  a_r5_status_capture: assert property (@(posedge clk) disable iff (!rstN)
    ($past(abortValid) && rdEn && regSel == 4'd5) |-> rdData == {24'd0, $past(abortDomain), $past(abortType)});

  // R7: a captured address survives a colliding software write
  a_r7_addr_capture: assert property (@(posedge clk) disable iff (!rstN)
    ($past(abortValid) && rdEn && regSel == 4'd6) |-> rdData == $past(abortAddr));

  // R10: unimplemented numbers and register 8 read as zero
  a_r10_unimpl_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEn || !(regSel inside {4'd1, 4'd2, 4'd3, 4'd5, 4'd6})) |-> rdData == 32'd0);
endmodule

bind mmu_regfile mmu_regfile_chk u_chk (.*);

// File: tb/mmu_regfile_tb.sv
module mmu_regfile_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regSel = '0;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [1:0]  tlbOp = '0;
  logic [31:0] rdData;
  logic        abortValid = 1'b0;
  logic [3:0]  abortType = '0;
  logic [3:0]  abortDomain = '0;
  logic [31:0] abortAddr = '0;
  logic        ctlMmuEn, ctlAlignEn, ctlProtS, ctlProtR;
  logic [31:0] tableBase, domainAccess, tlbInvAddr;
  logic        tlbInvAll, tlbInvEntry;

  int total = 0;
  int bad = 0;

  // behavioural reference state
  int unsigned mCtl, mBase, mDom, mFs, mFa, mInvAddr;
  bit mInvAll, mInvEntry;

  mmu_regfile u_dut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .tlbOp(tlbOp), .rdData(rdData), .abortValid(abortValid),
    .abortType(abortType), .abortDomain(abortDomain), .abortAddr(abortAddr),
    .ctlMmuEn(ctlMmuEn), .ctlAlignEn(ctlAlignEn), .ctlProtS(ctlProtS),
    .ctlProtR(ctlProtR), .tableBase(tableBase), .domainAccess(domainAccess),
    .tlbInvAll(tlbInvAll), .tlbInvEntry(tlbInvEntry), .tlbInvAddr(tlbInvAddr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int unsigned modelRead(input int sel, input bit en);
    if (!en) return 0;
    case (sel)
      1: return mCtl;
      2: return mBase;
      3: return mDom;
      5: return mFs;
      6: return mFa;
      default: return 0;
    endcase
  endfunction

  function automatic string readTag(input int sel);
    case (sel)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCtl = 0; mBase = 0; mDom = 0; mFs = 0; mFa = 0;
      mInvAll = 0; mInvEntry = 0; mInvAddr = 0;
    end else begin
      mInvAll   = wrEn && regSel == 8 && tlbOp == 1;
      mInvEntry = wrEn && regSel == 8 && tlbOp == 2;
      mInvAddr  = mInvEntry ? wrData : 0;
      if (wrEn) begin
        if (regSel == 1) mCtl = wrData & 32'hF;
        if (regSel == 2) mBase = wrData & 32'hFFFF_C000;
        if (regSel == 3) mDom = wrData;
        if (regSel == 5) mFs = wrData & 32'hFF;
        if (regSel == 6) mFa = wrData;
      end
      if (abortValid) begin
        mFs = {24'd0, abortDomain, abortType};
        mFa = abortAddr;
      end
    end
  end

  // compare every output against the model each cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check("R2 ctl", {28'd0, ctlProtR, ctlProtS, ctlAlignEn, ctlMmuEn}, mCtl);
      check("R3 base", tableBase, mBase);
      check("R4 dom", domainAccess, mDom);
      check("R8 invAll", {31'd0, tlbInvAll}, {31'd0, mInvAll});
      check("R9 invEntry", {31'd0, tlbInvEntry}, {31'd0, mInvEntry});
      check("R9 invAddr", tlbInvAddr, mInvAddr);
      check(readTag(regSel), rdData, modelRead(regSel, rdEn));
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wr(input int sel, input logic [31:0] d, input logic [1:0] op);
    regSel = sel[3:0]; wrData = d; tlbOp = op; wrEn = 1'b1; rdEn = 1'b0;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic rdCheck(input int sel, input logic [31:0] exp, input string tag);
    regSel = sel[3:0]; rdEn = 1'b1; #1;
    check(tag, rdData, exp);
    tick();
    rdEn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 2);
    // R1: state during reset
    check("R1 base", tableBase, 0);
    check("R1 invAll", {31'd0, tlbInvAll}, 0);
    rstN = 1'b1;
    tick();
    rdCheck(1, 0, "R1 ctl read");
    rdCheck(6, 0, "R1 faddr read");

    // R2: only four control bits stored
    wr(1, 32'hFFFF_FFF5, 2'd0);
    rdCheck(1, 32'h5, "R2 ctl masked");
    check("R2 mmu enable", {31'd0, ctlMmuEn}, 1);
    check("R2 align", {31'd0, ctlAlignEn}, 0);
    check("R2 protS", {31'd0, ctlProtS}, 1);

    // R3: table base alignment
    wr(2, 32'h1234_5FFF, 2'd0);
    rdCheck(2, 32'h1234_4000, "R3 base aligned");

    // R4: domain fields
    wr(3, 32'hC000_0003, 2'd0);
    check("R4 domain15 field", {30'd0, domainAccess[31:30]}, 3);
    check("R4 domain0 field", {30'd0, domainAccess[1:0]}, 3);
    check("R4 domain1 field", {30'd0, domainAccess[3:2]}, 0);

    // R6: software writes to fault registers
    wr(5, 32'hFFFF_FFA7, 2'd0);
    rdCheck(5, 32'hA7, "R6 fstat masked");
    wr(6, 32'hDEAD_BEEF, 2'd0);
    rdCheck(6, 32'hDEAD_BEEF, "R6 faddr");

    // R5: abort capture
    abortValid = 1'b1; abortType = 4'hD; abortDomain = 4'h9; abortAddr = 32'h8000_1234;
    tick();
    abortValid = 1'b0;
    rdCheck(5, 32'h9D, "R5 fstat capture");
    rdCheck(6, 32'h8000_1234, "R5 faddr capture");

    // R7: abort beats simultaneous software writes
    abortValid = 1'b1; abortType = 4'h5; abortDomain = 4'h2; abortAddr = 32'h0000_ABCD;
    wr(5, 32'hFF, 2'd0);
    abortValid = 1'b0;
    rdCheck(5, 32'h25, "R7 fstat priority");
    abortValid = 1'b1; abortAddr = 32'h1111_2222;
    wr(6, 32'h3333_4444, 2'd0);
    abortValid = 1'b0;
    rdCheck(6, 32'h1111_2222, "R7 faddr priority");

    // R8: invalidate-all pulse, back to back
    regSel = 4'd8; wrData = 32'h0; tlbOp = 2'd1; wrEn = 1'b1;
    @(posedge clk); #1;
    check("R8 pulse high", {31'd0, tlbInvAll}, 1);
    @(posedge clk); #1;
    wrEn = 1'b0;
    check("R8 second pulse", {31'd0, tlbInvAll}, 1);
    @(posedge clk); #1;
    check("R8 pulse ends", {31'd0, tlbInvAll}, 0);

    // R9: invalidate-entry with address
    regSel = 4'd8; wrData = 32'h0040_2000; tlbOp = 2'd2; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
    check("R9 entry pulse", {31'd0, tlbInvEntry}, 1);
    check("R9 entry addr", tlbInvAddr, 32'h0040_2000);
    @(posedge clk); #1;
    check("R9 entry ends", {31'd0, tlbInvEntry}, 0);
    check("R9 addr cleared", tlbInvAddr, 0);

    // R10: reserved opcodes do nothing, register 8 reads zero
    regSel = 4'd8; tlbOp = 2'd3; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
    check("R10 rsvd op", {30'd0, tlbInvEntry, tlbInvAll}, 0);
    rdCheck(8, 0, "R10 reg8 read");
    rdCheck(4, 0, "R10 reg4 read");
    rdCheck(15, 0, "R10 reg15 read");

    // R11: unimplemented writes leave all state untouched
    for (int s = 0; s < 16; s++) begin
      if (!(s inside {1, 2, 3, 5, 6, 8})) wr(s, 32'hFFFF_FFFF, 2'd0);
    end
    rdCheck(1, 32'h5, "R11 ctl kept");
    rdCheck(2, 32'h1234_4000, "R11 base kept");
    rdCheck(3, 32'hC000_0003, "R11 dom kept");

    // random phase: model compared every cycle
    for (int i = 0; i < 2000; i++) begin
      regSel = 4'($urandom_range(0, 15));
      rdEn = 1'($urandom);
      wrEn = ($urandom_range(0, 2) == 0);
      wrData = $urandom;
      tlbOp = 2'($urandom);
      abortValid = ($urandom_range(0, 3) == 0);
      abortType = 4'($urandom);
      abortDomain = 4'($urandom);
      abortAddr = $urandom;
      tick();
    end
    wrEn = 1'b0; rdEn = 1'b0; abortValid = 1'b0;
    tick();

    // R1: reset again mid-run
    rstN = 1'b0;
    #2;
    check("R1 reset domain", domainAccess, 0);
    check("R1 reset ctl", {31'd0, ctlMmuEn}, 0);
    rstN = 1'b1;
    tick();
    rdCheck(5, 0, "R1 fstat after reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule